// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block holds the digital fault logic of a multiphase voltage regulator controller. Four comparator flags arrive from analog circuitry and are taken into account only on cycles where the phase-tick strobe is high. These flags report an output above the overvoltage level, an output below the overvoltage release level, an output below the undervoltage level, and an averaged phase current above the overcurrent threshold. From these flags the block drives the gate-control overrides and a request that pulls power-good low.

Overvoltage is handled by a crowbar with hysteresis. On the first overvoltage tick, PWM is forced low and the low-side switches are turned on, which shunts the output. Once the output falls below the release level, every switch is held off. Each further overvoltage tick brings the shunt back. This crowbar state is cleared only by power-on reset.

Undervoltage passes through a filter that needs a run of consecutive ticks. Overcurrent passes through an up/down persistence counter. Either fault, once confirmed, sets a latched shutdown. The shutdown turns every switch off and overrides all other outputs. It is cleared by power-on reset or by taking the enable input low.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all outputs are 0.
- R2: A tick with `ov_hi`=1 moves the crowbar to shunt from the next cycle: `pwm_force_low`=1, `lowside_on`=1, `all_off`=0, `pg_pull_low`=1.
- R3: In shunt, a tick with `ov_rel_lo`=1 and `ov_hi`=0 moves the crowbar to hold-off: `all_off`=1, `pwm_force_low`=0, `lowside_on`=0, `pg_pull_low`=1.
- R4: In hold-off, a tick with `ov_hi`=1 returns the crowbar to shunt, so repeated overvoltage alternates between shunt and hold-off.
- R5: Once set, the crowbar state is cleared only by `rst_n`. Taking `en` low and back high leaves it unchanged.
- R6: `shutdown` rises after more than UV_LIMIT (default 32) consecutive ticks with `uv_lo`=1. It sets on the 33rd such tick and not on the 32nd.
- R7: A tick with `uv_lo`=0 restarts the undervoltage run from zero.
- R8: The overcurrent count rises on each tick with `oc_hi`=1 and falls on each tick with `oc_hi`=0, never going below zero. `shutdown` sets on the tick where the count reaches OC_LIMIT (default 32).
- R9: `en`=0 clears the latched shutdown and both persistence counts, and keeps them at zero while it is held low.
- R10: While `shutdown`=1, the outputs are `all_off`=1, `pwm_force_low`=0, `lowside_on`=0 and `pg_pull_low`=1, whatever the crowbar state.
- R11: Flag values on cycles with `tick`=0 have no effect on any state or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| en | input | 1 | Enable; low clears the latched shutdown |
| tick | input | 1 | Phase clock strobe; flags are sampled only when it is high |
| ov_hi | input | 1 | Output above the overvoltage level |
| ov_rel_lo | input | 1 | Output below the overvoltage release level |
| uv_lo | input | 1 | Output below the undervoltage level |
| oc_hi | input | 1 | Averaged current above the overcurrent threshold |
| pwm_force_low | output | 1 | Forces the PWM signal low |
| lowside_on | output | 1 | Turns the low-side switches on |
| all_off | output | 1 | Holds every switch off |
| shutdown | output | 1 | Latched undervoltage or overcurrent shutdown |
| pg_pull_low | output | 1 | Request to pull power-good low |

## Verification
Some properties are checked on every cycle. These are: shutdown overrides all other outputs, low-side-on and all-off are never both high, the crowbar never returns to idle without reset, non-tick cycles leave the state unchanged, counters stay within their limit, and the undervoltage run restarts on a clean tick. Other behaviour can only be shown by the bench's scenarios. This covers the exact tick on which each filter trips, for undervoltage runs swept around the limit. It covers overcurrent counts under a long pseudo-random over/under pattern scored against an arithmetic count with a floor at zero. It also covers the shunt and hold-off alternation, and the fact that an enable toggle clears one fault class but leaves the other in place.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    OV_IDLE  = 2'd0,
    OV_SHUNT = 2'd1,
    OV_OFF   = 2'd2
  } ov_state_t;
endpackage

// File: rtl/fsup_persist_filter.sv
module fsup_persist_filter #(
  parameter int LIMIT  = 32,
  parameter bit UPDOWN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          trip_q, trip_d;

  generate
    if (UPDOWN) begin : g_updown
      always_comb begin
        cnt_d  = cnt_q;
        trip_d = trip_q;
        if (clr) begin
          cnt_d  = '0;
          trip_d = 1'b0;
        end else if (tick && !trip_q) begin
          if (flag) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LIM_M1) trip_d = 1'b1;
          end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      // R8: a down tick at zero keeps the count at zero
      p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flag && !clr && !trip_q && cnt_q == '0) |=> (cnt_q == '0));
    end else begin : g_consec
      always_comb begin
        cnt_d  = cnt_q;
        trip_d = trip_q;
        if (clr) begin
          cnt_d  = '0;
          trip_d = 1'b0;
        end else if (tick && !trip_q) begin
          if (!flag)            cnt_d  = '0;
          else if (cnt_q == LIM) trip_d = 1'b1;
          else                  cnt_d  = cnt_q + 1'b1;
        end
      end
      p_run_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flag && !clr && !trip_q) |=> (cnt_q == '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign trip = trip_q;

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr) |=> trip_q);
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!trip_q && cnt_q == '0));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> ($stable(cnt_q) && $stable(trip_q)));
endmodule

// File: rtl/fsup_ov_crowbar.sv
module fsup_ov_crowbar
  import fsup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ov_hi,
  input  logic ov_rel_lo,
  output logic shunt,
  output logic hold_off,
  output logic active
);
  ov_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (tick) begin
      unique case (state_q)
        OV_IDLE:  if (ov_hi) state_d = OV_SHUNT;
        OV_SHUNT: if (!ov_hi && ov_rel_lo) state_d = OV_OFF;
        OV_OFF:   if (ov_hi) state_d = OV_SHUNT;
        default:  state_d = OV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OV_IDLE;
    else        state_q <= state_d;
  end

  assign shunt    = (state_q == OV_SHUNT);
  assign hold_off = (state_q == OV_OFF);
  assign active   = (state_q != OV_IDLE);

  p_ov_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != OV_IDLE) |=> (state_q != OV_IDLE));
  p_ov_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ov_hi) |=> (state_q == OV_SHUNT));
  p_ov_notick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int UV_LIMIT = 32,
  parameter int OC_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic ov_hi,
  input  logic ov_rel_lo,
  input  logic uv_lo,
  input  logic oc_hi,
  output logic pwm_force_low,
  output logic lowside_on,
  output logic all_off,
  output logic shutdown,
  output logic pg_pull_low
);
  logic uv_trip, oc_trip, ov_shunt, ov_hold, ov_active, clr;

  assign clr = ~en;

  fsup_ov_crowbar u_ov (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ov_hi(ov_hi), .ov_rel_lo(ov_rel_lo),
    .shunt(ov_shunt), .hold_off(ov_hold), .active(ov_active)
  );

  fsup_persist_filter #(.LIMIT(UV_LIMIT), .UPDOWN(1'b0)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .flag(uv_lo), .trip(uv_trip)
  );

  fsup_persist_filter #(.LIMIT(OC_LIMIT), .UPDOWN(1'b1)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .flag(oc_hi), .trip(oc_trip)
  );

  assign shutdown = uv_trip | oc_trip;

  always_comb begin
    pwm_force_low = 1'b0;
    lowside_on    = 1'b0;
    all_off       = 1'b0;
    if (shutdown) begin
      all_off = 1'b1;
    end else if (ov_shunt) begin
      pwm_force_low = 1'b1;
      lowside_on    = 1'b1;
    end else if (ov_hold) begin
      all_off = 1'b1;
    end
  end

  assign pg_pull_low = shutdown | ov_active;

  p_latched_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (all_off && !pwm_force_low && !lowside_on && pg_pull_low));
  p_gate_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lowside_on, all_off}));
  p_shunt_pg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lowside_on |-> (pwm_force_low && pg_pull_low));
endmodule

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
  logic clk = 1'b0;
  logic rst_n, en, tick, ov_hi, ov_rel_lo, uv_lo, oc_hi;
  logic pwm_force_low, lowside_on, all_off, shutdown, pg_pull_low;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fault_supervisor dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ov_hi(ov_hi),
    .ov_rel_lo(ov_rel_lo), .uv_lo(uv_lo), .oc_hi(oc_hi),
    .pwm_force_low(pwm_force_low), .lowside_on(lowside_on), .all_off(all_off),
    .shutdown(shutdown), .pg_pull_low(pg_pull_low)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {pwm_force_low, lowside_on, all_off, shutdown, pg_pull_low};
  endfunction

  // one clock cycle; inputs change 1 ns after the edge, outputs read there too
  task automatic step(input logic t, input logic ov, input logic rel,
                      input logic uv, input logic oc);
    tick = t; ov_hi = ov; ov_rel_lo = rel; uv_lo = uv; oc_hi = oc;
    @(posedge clk); #1;
    tick = 0; ov_hi = 0; ov_rel_lo = 0; uv_lo = 0; oc_hi = 0;
  endtask

  task automatic en_toggle();
    en = 1'b0; step(0, 0, 0, 0, 0);
    en = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; #3;
    check("R1 outputs in reset", outs(), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    check("R1 outputs after reset", outs(), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    en = 1; tick = 0; ov_hi = 0; ov_rel_lo = 0; uv_lo = 0; oc_hi = 0;
    rst_n = 1'b0;
    #12;
    do_reset();

    // R11: flags without tick do nothing (outputs order pwm,ls,off,sd,pg)
    for (int i = 0; i < 40; i++) step(0, 1, 1, 1, 1);
    check("R11 no tick no effect", outs(), 0);

    // OV crowbar
    step(1, 1, 0, 0, 0);
    check("R2 shunt entry", outs(), 5'b11001);
    step(1, 0, 1, 0, 0);
    check("R3 hold-off after release", outs(), 5'b00101);
    step(0, 1, 0, 0, 0);
    check("R11 hold-off ignores untimed ov", outs(), 5'b00101);
    step(1, 1, 0, 0, 0);
    check("R4 shunt again", outs(), 5'b11001);
    step(1, 0, 1, 0, 0);
    check("R4 hold-off again", outs(), 5'b00101);
    en_toggle();
    step(0, 0, 0, 0, 0);
    check("R5 enable toggle keeps ov", outs(), 5'b00101);
    do_reset();
    check("R5 reset clears ov", outs(), 0);

    // R6 sweep of run length around the limit
    for (int n = 28; n <= 36; n++) begin
      en_toggle();
      for (int k = 0; k < n; k++) step(1, 0, 0, 1, 0);
      check($sformatf("R6 run of %0d", n), shutdown, (n > 32) ? 1 : 0);
      if (n > 32) check("R10 shutdown outputs", outs(), 5'b00111);
    end
    en_toggle();
    check("R9 enable clears shutdown", outs(), 0);

    // R7 restart
    for (int k = 0; k < 32; k++) step(1, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < 32; k++) step(1, 0, 0, 1, 0);
    check("R7 run restarted", shutdown, 0);
    step(1, 0, 0, 1, 0);
    check("R7 33rd of new run trips", shutdown, 1);

    // R9: enable low holds counts at zero
    en = 1'b0;
    for (int k = 0; k < 40; k++) step(1, 0, 0, 1, 1);
    en = 1'b1;
    step(1, 0, 0, 1, 0);
    check("R9 counts held while disabled", shutdown, 0);
    en_toggle();

    // R8 floor then count
    for (int k = 0; k < 10; k++) step(1, 0, 0, 0, 0);
    for (int k = 0; k < 31; k++) step(1, 0, 0, 0, 1);
    check("R8 floor at zero, 31 up", shutdown, 0);
    step(1, 0, 0, 0, 1);
    check("R8 reaching 32 trips", shutdown, 1);

    // R10 priority over crowbar
    step(1, 1, 0, 0, 0);
    check("R10 shutdown beats shunt", outs(), 5'b00111);
    en_toggle();
    check("R5 shunt survives enable toggle", outs(), 5'b11001);
    do_reset();

    // R8 pseudo-random over/under sweep against arithmetic count
    begin
      logic [15:0] lf = 16'hACE1;
      int m = 0;
      bit exp_trip = 0;
      for (int i = 0; i < 3000; i++) begin
        logic b;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        b = (lf[2:0] != 3'd0) && (lf[4:3] != 2'd0);
        step(1, 0, 0, 0, b);
        if (b) begin
          if (m == 31) exp_trip = 1; else m++;
        end else if (m > 0) m--;
        check($sformatf("R8 sweep tick %0d", i), shutdown, exp_trip);
        if (exp_trip) begin
          en_toggle();
          m = 0; exp_trip = 0;
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule